// File: doc/BRIEF.md
# System Reset Sequencer with Low-Voltage Supervision

This block merges every digital reset request of a small microcontroller into one system reset output. Power-on drops the controller straight into reset without waiting for a clock. A low-voltage condition holds reset until the supply has recovered. Periodic-wakeup, watchdog and over-cold requests count only when their enable is set. Single-cycle illegal-opcode and illegal-address strobes from the processor each become a full reset sequence. Once every request has gone away, reset stays asserted for a fixed stretch of cycles. At the moment of release, a sticky status register is rewritten so that it names exactly the causes of the reset just ended. Software reads that register after restart.

The block also holds the control bits that supervise the supply monitor. It reports whether the low-voltage detector is live in the current power mode, and whether a request for the deepest stop mode may be honoured. The analog comparators reach the block as four digital inputs, one falling-trip and one rising-trip pair for each of the two selectable thresholds. This gives the block its hysteresis.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, the block is asynchronously in reset: `sys_rst_o`=1, `status_o`=0x03 (bit0 power-on, bit1 low-voltage), `ctl_o`=0x10.
- R2: After `por_i` falls, reset stays asserted until the rising comparator of the selected threshold reports the supply above it. Release then follows R6.
- R3: When `ctl_o` bit2 (low-voltage reset enable) is set, the detector is live and the selected falling comparator reports the supply below it, reset is asserted. Reset is held while the rising comparator of the selected threshold stays low.
- R4: A periodic-wakeup, watchdog or over-cold request causes reset only when its enable is set: `ctl_o` bit0, bit1 and bit3 respectively. With the enable clear, the request has no effect.
- R5: A one-cycle pulse on `bad_opcode_i` or `bad_addr_i` produces a complete reset. Reset reads high on HOLD_CYC+1 consecutive samples.
- R6: `sys_rst_o` rises on the edge after a request is seen. It falls on the (HOLD_CYC+1)-th edge after the last cycle in which any request was present.
- R7: `status_o` changes only when reset is released. It then holds exactly the causes seen during that reset: bit2 wakeup, bit3 watchdog, bit4 over-cold, bit5 illegal opcode, bit6 illegal address, bit1 low-voltage.
- R8: While reset is active, `ctl_o` returns to 0x10 (only the detector enable, bit4, set), and writes are ignored. Outside reset, a write loads `ctl_wdata_i`.
- R9: `lvd_active_o` is 1 when `ctl_o` bit4 is set and either `stop_mode_i` is 0 or `ctl_o` bit5 (stop-mode detector enable) is set.
- R10: `stop1_ok_o` is 0 exactly when `ctl_o` bit4 and bit5 are both set.
- R11: `ctl_o` bit6 selects the threshold pair: 1 uses the `vhi_*` comparators, 0 uses the `vlo_*` comparators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| por_i | input | 1 | Supply below power-on level, asynchronous |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 7 | Control register write data |
| stop_mode_i | input | 1 | Chip is in a stop mode |
| vlo_below_i | input | 1 | Supply below low threshold (falling trip) |
| vlo_above_i | input | 1 | Supply above low threshold (rising trip) |
| vhi_below_i | input | 1 | Supply below high threshold (falling trip) |
| vhi_above_i | input | 1 | Supply above high threshold (rising trip) |
| pwu_elapsed_i | input | 1 | Periodic-wakeup reset interval elapsed |
| wdog_expire_i | input | 1 | Watchdog timeout |
| temp_low_i | input | 1 | Temperature below restart level |
| bad_opcode_i | input | 1 | Illegal-opcode strobe, one cycle |
| bad_addr_i | input | 1 | Illegal-address strobe, one cycle |
| sys_rst_o | output | 1 | System reset, active high |
| status_o | output | 7 | Sticky reset cause register |
| ctl_o | output | 7 | Control register value |
| lvd_active_o | output | 1 | Low-voltage detector live in current mode |
| stop1_ok_o | output | 1 | Deepest stop mode may be entered |

## Verification
On every cycle, the assertions check the following:
- any request is followed by reset on the next edge;
- the status register moves only at a release edge, and is never empty after a release;
- the release never comes before the minimum quiet stretch;
- the control register is back at its default after each cycle in reset;
- the low-voltage hold latch only sets while detection and its reset enable are both on.

Only the bench's scenarios can show the following:
- the exact cause encoding in the status register;
- the exact release edge;
- the effect of the threshold select on which comparator pair counts;
- a disabled request, or a detector switched off in stop mode, leaving the system running.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int STAT_W = 7;
  localparam int CTL_W  = 7;

  // status bit positions
  localparam int S_POR  = 0;
  localparam int S_LVD  = 1;
  localparam int S_PWU  = 2;
  localparam int S_WDOG = 3;
  localparam int S_TEMP = 4;
  localparam int S_BOP  = 5;
  localparam int S_BADR = 6;

  typedef struct packed {
    logic trip_hi;     // bit6
    logic lv_stop_en;  // bit5
    logic lv_en;       // bit4
    logic temp_en;     // bit3
    logic lv_rst_en;   // bit2
    logic wdog_en;     // bit1
    logic pwu_en;      // bit0
  } ctl_t;

  localparam logic [CTL_W-1:0] CTL_DEFAULT = 7'h10;
  localparam logic [STAT_W-1:0] STAT_POR   = 7'h03;

  function automatic logic [STAT_W-1:0] build_req(
    input ctl_t c, input logic lv_hold, input logic pwu, input logic wdog,
    input logic temp, input logic bop, input logic badr);
    logic [STAT_W-1:0] r;
    r         = '0;
    r[S_LVD]  = lv_hold;
    r[S_PWU]  = pwu  & c.pwu_en;
    r[S_WDOG] = wdog & c.wdog_en;
    r[S_TEMP] = temp & c.temp_en;
    r[S_BOP]  = bop;
    r[S_BADR] = badr;
    return r;
  endfunction
endpackage

// File: rtl/rstc_lvd.sv
module rstc_lvd (
  input  logic clk_i,
  input  logic por_i,
  input  logic lv_en_i,
  input  logic lv_stop_en_i,
  input  logic lv_rst_en_i,
  input  logic trip_hi_i,
  input  logic stop_mode_i,
  input  logic vlo_below_i,
  input  logic vlo_above_i,
  input  logic vhi_below_i,
  input  logic vhi_above_i,
  output logic lv_hold_o,
  output logic lvd_active_o,
  output logic stop1_ok_o
);
  logic below_sel, above_sel, trip_evt;
  logic lv_hold_q;

  assign below_sel    = trip_hi_i ? vhi_below_i : vlo_below_i;
  assign above_sel    = trip_hi_i ? vhi_above_i : vlo_above_i;
  assign lvd_active_o = lv_en_i & (~stop_mode_i | lv_stop_en_i);
  assign stop1_ok_o   = ~(lv_en_i & lv_stop_en_i);
  assign trip_evt     = lvd_active_o & lv_rst_en_i & below_sel;

  // power-on leaves the hold set; only a rising-threshold crossing clears it
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)          lv_hold_q <= 1'b1;
    else if (above_sel) lv_hold_q <= 1'b0;
    else if (trip_evt)  lv_hold_q <= 1'b1;
  end
  assign lv_hold_o = lv_hold_q;

  // R3: the hold only sets when detection and its reset enable are on
  p_hold_set_gated_r3: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(lv_hold_q) |-> $past(lvd_active_o && lv_rst_en_i));
  // R2: a rising-threshold crossing always releases the hold
  p_hold_clear_r2: assert property (@(posedge clk_i) disable iff (por_i)
    above_sel |=> !lv_hold_q);
endmodule

// File: rtl/rstc_ctl.sv
module rstc_ctl
  import rstc_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             in_rst_i,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)         ctl_q <= CTL_DEFAULT;
    else if (in_rst_i) ctl_q <= CTL_DEFAULT;
    else if (we_i)     ctl_q <= wdata_i;
  end
  assign ctl_o = ctl_t'(ctl_q);

  p_ctl_default_r8: assert property (@(posedge clk_i) disable iff (por_i)
    in_rst_i |=> (ctl_q == CTL_DEFAULT));
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic [STAT_W-1:0] req_i,
  output logic              in_rst_o,
  output logic              release_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 2);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

  function automatic logic [CNT_W-1:0] next_cnt(input logic any, input logic [CNT_W-1:0] c);
    if (any)       return HOLD_V;
    else if (c != '0) return c - 1'b1;
    else           return '0;
  endfunction

  logic              any_req, rst_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_rst_q;
  logic [STAT_W-1:0] cause_q, cause_d, status_q;

  assign any_req   = |req_i;
  assign rst_d     = any_req | (cnt_q != '0);
  assign release_o = in_rst_q & ~rst_d;
  assign cause_d   = (in_rst_q ? cause_q : '0) | req_i;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cnt_q    <= HOLD_V;
      in_rst_q <= 1'b1;
      cause_q  <= STAT_POR;
      status_q <= STAT_POR;
    end else begin
      cnt_q    <= next_cnt(any_req, cnt_q);
      in_rst_q <= rst_d;
      cause_q  <= rst_d ? cause_d : '0;
      if (release_o) status_q <= cause_d;
    end
  end
  assign in_rst_o = in_rst_q;
  assign status_o = status_q;

  // checker-side count of quiet cycles since the last request
  logic [CNT_W-1:0] quiet_q;
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                quiet_q <= '0;
    else if (any_req)         quiet_q <= '0;
    else if (quiet_q <= HOLD_V) quiet_q <= quiet_q + 1'b1;
  end

  p_req_enters_rst_r6: assert property (@(posedge clk_i) disable iff (por_i)
    any_req |=> in_rst_q);
  p_hold_min_r6: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(in_rst_q) |-> (quiet_q >= HOLD_V));
  p_status_only_release_r7: assert property (@(posedge clk_i) disable iff (por_i)
    !release_o |=> $stable(status_q));
  p_status_named_r7: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(in_rst_q) |-> (status_q != '0));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              stop_mode_i,
  input  logic              vlo_below_i,
  input  logic              vlo_above_i,
  input  logic              vhi_below_i,
  input  logic              vhi_above_i,
  input  logic              pwu_elapsed_i,
  input  logic              wdog_expire_i,
  input  logic              temp_low_i,
  input  logic              bad_opcode_i,
  input  logic              bad_addr_i,
  output logic              sys_rst_o,
  output logic [STAT_W-1:0] status_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              lvd_active_o,
  output logic              stop1_ok_o
);
  ctl_t              ctl;
  logic              lv_hold, in_rst, rel_evt;
  logic [STAT_W-1:0] req;

  rstc_ctl u_ctl (
    .clk_i(clk_i), .por_i(por_i), .in_rst_i(in_rst),
    .we_i(ctl_we_i), .wdata_i(ctl_wdata_i), .ctl_o(ctl)
  );

  rstc_lvd u_lvd (
    .clk_i(clk_i), .por_i(por_i),
    .lv_en_i(ctl.lv_en), .lv_stop_en_i(ctl.lv_stop_en),
    .lv_rst_en_i(ctl.lv_rst_en), .trip_hi_i(ctl.trip_hi),
    .stop_mode_i(stop_mode_i),
    .vlo_below_i(vlo_below_i), .vlo_above_i(vlo_above_i),
    .vhi_below_i(vhi_below_i), .vhi_above_i(vhi_above_i),
    .lv_hold_o(lv_hold), .lvd_active_o(lvd_active_o), .stop1_ok_o(stop1_ok_o)
  );

  assign req = build_req(ctl, lv_hold, pwu_elapsed_i, wdog_expire_i,
                         temp_low_i, bad_opcode_i, bad_addr_i);

  rstc_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i(clk_i), .por_i(por_i), .req_i(req),
    .in_rst_o(in_rst), .release_o(rel_evt), .status_o(status_o)
  );

  assign sys_rst_o = in_rst;
  assign ctl_o     = CTL_W'(ctl);

  // R5: strobes from the CPU always start a reset
  p_strobe_rst_r5: assert property (@(posedge clk_i) disable iff (por_i)
    (bad_opcode_i || bad_addr_i) |=> sys_rst_o);
  // R7: a release never leaves status without a cause of the ended reset
  p_release_cause_r7: assert property (@(posedge clk_i) disable iff (por_i)
    rel_evt |=> (status_o != '0));
endmodule

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
  localparam int HOLD = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       por = 1'b1, we = 1'b0, stop = 1'b0;
  logic [6:0] wd = '0;
  logic       vlb, vla, vhb, vha;
  logic       pwu = 0, wdg = 0, tmp = 0, bop = 0, badr = 0;
  logic       rst, lva, s1ok;
  logic [6:0] stat, ctl;
  int         volt = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  // comparator levels from a 0..7 supply value; low pair trips 2/3, high pair 5/6
  always_comb begin
    vlb = (volt < 2); vla = (volt >= 3);
    vhb = (volt < 5); vha = (volt >= 6);
  end

  rstc_top #(.HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .por_i(por), .ctl_we_i(we), .ctl_wdata_i(wd),
    .stop_mode_i(stop), .vlo_below_i(vlb), .vlo_above_i(vla),
    .vhi_below_i(vhb), .vhi_above_i(vha), .pwu_elapsed_i(pwu),
    .wdog_expire_i(wdg), .temp_low_i(tmp), .bad_opcode_i(bop),
    .bad_addr_i(badr), .sys_rst_o(rst), .status_o(stat), .ctl_o(ctl),
    .lvd_active_o(lva), .stop1_ok_o(s1ok)
  );

  // reference state
  logic [6:0] m_ctl, m_stat, m_cause;
  int         m_cnt;
  logic       m_rst, m_lvh;

  function automatic logic exp_active(input logic [6:0] c, input logic s);
    return c[4] && (!s || c[5]);
  endfunction

  task automatic model_por();
    m_ctl = 7'h10; m_stat = 7'h03; m_cause = 7'h03;
    m_cnt = HOLD; m_rst = 1; m_lvh = 1;
  endtask

  task automatic model_edge();
    logic below, above, any, rst_n;
    logic [6:0] req, cause_n;
    below = m_ctl[6] ? (volt < 5) : (volt < 2);
    above = m_ctl[6] ? (volt >= 6) : (volt >= 3);
    req = {badr, bop, tmp && m_ctl[3], wdg && m_ctl[1], pwu && m_ctl[0], m_lvh, 1'b0};
    any = |req;
    rst_n = any || (m_cnt != 0);
    cause_n = (m_rst ? m_cause : 7'h0) | req;
    if (m_rst && !rst_n) m_stat = cause_n;
    m_cause = rst_n ? cause_n : 7'h0;
    if (above) m_lvh = 0;
    else if (exp_active(m_ctl, stop) && m_ctl[2] && below) m_lvh = 1;
    m_cnt = any ? HOLD : (m_cnt != 0 ? m_cnt - 1 : 0);
    m_ctl = m_rst ? 7'h10 : (we ? wd : m_ctl);
    m_rst = rst_n;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 sys_rst", rst, m_rst);
    chk("R7 status", stat, m_stat);
    chk("R8 ctl", ctl, m_ctl);
    chk("R9 lvd_active", lva, exp_active(m_ctl, stop));
    chk("R10 stop1_ok", s1ok, !(m_ctl[4] && m_ctl[5]));
  endtask

  task automatic step();
    @(posedge clk);
    if (por) model_por(); else model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic write_ctl(input logic [6:0] v);
    we = 1; wd = v; step(); we = 0;
  endtask

  task automatic run_out();
    for (int i = 0; i < 60 && rst; i++) step();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    model_por();
    volt = 0;
    @(negedge clk);
    // R1: asynchronous power-on state
    chk("R1 rst", rst, 1); chk("R1 status", stat, 7'h03); chk("R1 ctl", ctl, 7'h10);
    repeat (2) step();
    por = 0;
    // R2: stays in reset while supply under low rising threshold
    for (int i = 0; i < 20; i++) step();
    chk("R2 held low supply", rst, 1);
    volt = 4; run_out();
    chk("R2 released", rst, 0);
    chk("R1 status after power-on", stat, 7'h03);

    // R4: disabled watchdog ignored
    write_ctl(7'h10);
    wdg = 1; repeat (3) step(); wdg = 0; step();
    chk("R4 disabled wdog", rst, 0);
    chk("R4 status unchanged", stat, 7'h03);
    write_ctl(7'h12);
    wdg = 1; step(); wdg = 0;
    chk("R4 enabled wdog", rst, 1);
    // R8: write during reset ignored
    write_ctl(7'h7f);
    chk("R8 write ignored", ctl, 7'h10);
    run_out();
    chk("R7 wdog cause", stat, 7'h08);

    // R5/R6: illegal opcode strobe length
    bop = 1; step(); bop = 0;
    n = 0;
    while (rst && n < 40) begin n++; step(); end
    chk("R5 strobe reset length", n, HOLD + 1);
    chk("R7 opcode cause", stat, 7'h20);
    badr = 1; step(); badr = 0; run_out();
    chk("R7 address cause", stat, 7'h40);

    // R3: low-voltage reset held until recovery
    write_ctl(7'h14);
    volt = 1; step(); step();
    chk("R3 lv reset", rst, 1);
    for (int i = 0; i < 20; i++) step();
    chk("R3 held", rst, 1);
    volt = 7; run_out();
    chk("R3 lv cause", stat, 7'h02);

    // R11: select picks comparator pair
    write_ctl(7'h14); volt = 4; repeat (3) step();
    chk("R11 low pair no trip", rst, 0);
    write_ctl(7'h54); step(); step();
    chk("R11 high pair trips", rst, 1);
    run_out();
    volt = 7; run_out();

    // R9: detector off in stop without stop enable
    stop = 1; write_ctl(7'h14); volt = 1; repeat (3) step();
    chk("R9 inactive in stop", lva, 0);
    chk("R9 no reset in stop", rst, 0);
    volt = 7; step(); write_ctl(7'h34);
    chk("R9 active with stop enable", lva, 1);
    // R10
    chk("R10 stop1 refused", s1ok, 0);
    volt = 1; step(); step();
    chk("R9 reset in stop with enable", rst, 1);
    volt = 7; run_out(); stop = 0;
    chk("R10 stop1 allowed after reset", s1ok, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      we = (r < 6) && !rst; wd = 7'($urandom);
      pwu = ($urandom_range(0, 99) < 3); wdg = ($urandom_range(0, 99) < 3);
      tmp = ($urandom_range(0, 99) < 3);
      bop = ($urandom_range(0, 199) < 2); badr = ($urandom_range(0, 199) < 2);
      stop = ($urandom_range(0, 9) < 2);
      if ($urandom_range(0, 99) < 8) volt = $urandom_range(0, 7);
      else if ($urandom_range(0, 99) < 10) volt = 7;
      if (r == 99) begin por = 1; #1; model_por(); end
      step();
      por = 0;
    end
    we = 0; pwu = 0; wdg = 0; tmp = 0; bop = 0; badr = 0;

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule